// File: doc/BRIEF.md
# Per-Bank Cache Request Scheduler

This block sits at the front of a banked cache. In every cycle it fills at most one request slot per bank, and it draws on three kinds of work. The first is a pending replay out of the miss-holding registers. The second is a returning memory fill. The third is a set of core request ports. It splits each core address into word offset, bank, set and tag. It merges core requests that target the same line, come from different ports and agree on read/write into one multi-port bank slot. Uncacheable requests go to a single bypass output. The input index is appended to the core tag there, so that the response can later be routed back.

When the miss-holding registers of the target bank are full, a core request is held back and counted as an MSHR stall. When the slot it needs is already held by an incompatible core request, the request is held back and counted as a bank stall. After reset, the scheduler accepts nothing until every line of the cache has been cleared, which takes one cycle per line. The per-bank slots, the bypass request and both stall counters are registered. The per-port ready and the replay/fill pop strobes are combinational and mark what is consumed at the coming clock edge.

Top module: `bank_req_sched`

## Requirements
- R1: After reset is released, no core port sees ready, and no replay or fill is popped, until SETS×WAYS rising edges have passed. With the defaults this is 8 edges. Acceptance starts in the cycle after the 8th edge.
- R2: Per bank, a pending replay wins the slot over a fill response, and a fill response wins it over any core request. The slot kind codes are 0 idle, 1 fill, 2 replay and 3 core. replay_pop and fill_pop mark which source was taken.
- R3: A non-IO core request whose bank slot already holds a replay or a fill gets no ready and is not counted as any stall.
- R4: Core ports are scanned from index 0 upward. An IO request takes the bypass output instead of a bank slot. Only the lowest-indexed IO request is taken in a cycle, and the others wait.
- R5: Address fields run from bit 0 upward in this order: word offset (OFF_W bits), bank (BANK_W), set (SET_W), tag (the remaining bits). A field of zero width reads as 0.
- R6: A core request from port p uses port slot p mod PPB, and that slot records p as its source. The request joins a bank slot that already holds a core request only when the write flag, set and tag all match and its port slot is empty.
- R7: When mshr_full is set for the target bank, a core read is held back. With WRITE_BACK=1 a core write is held back too. Each such request adds 1 to mshr_stalls.
- R8: A core request refused by a core-held slot, because of a field mismatch or an occupied port slot, adds 1 to bank_stalls and stays unready.
- R9: The bypass output carries byp_tag = core_tag × NUM_PORTS + port index, together with the request's address and write flag, one cycle after acceptance. byp_valid drops in the next cycle unless another IO request is accepted.
- R10: core_ready is asserted only for a valid request that is consumed at the coming edge.
- R11: During reset, all slots are idle, byp_valid is low and both stall counters are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| replay_rdy | input | NB | Per-bank replay pending |
| fill_rdy | input | NB | Per-bank fill response pending |
| mshr_full | input | NB | Per-bank miss-holding registers full |
| core_valid | input | NUM_PORTS | Core request valid |
| core_io | input | NUM_PORTS | Request is uncacheable |
| core_write | input | NUM_PORTS | Request is a write |
| core_addr | input | NUM_PORTS*ADDR_W | Request addresses, port 0 lowest |
| core_tag | input | NUM_PORTS*CTAG_W | Request tags |
| core_ready | output | NUM_PORTS | Request consumed this cycle |
| replay_pop | output | NB | Replay taken into the bank slot |
| fill_pop | output | NB | Fill taken into the bank slot |
| slot_kind | output | NB*2 | Registered slot kind per bank |
| slot_write | output | NB | Registered write flag per bank |
| slot_set | output | NB*SW | Registered set index per bank |
| slot_tag | output | NB*TW | Registered line tag per bank |
| slot_pmask | output | NB*PPB | Occupied port slots per bank |
| slot_psrc | output | NB*PPB*PW | Source port per port slot |
| byp_valid | output | 1 | Bypass request valid |
| byp_write | output | 1 | Bypass request is a write |
| byp_addr | output | ADDR_W | Bypass request address |
| byp_tag | output | CTAG_W+PW | Bypass tag with the port index appended |
| mshr_stalls | output | CNT_W | Saturating count of MSHR stalls |
| bank_stalls | output | CNT_W | Saturating count of bank stalls |

## Verification
The bench targets the end of the clearing window. A gate off by one edge would raise ready one cycle early or one cycle late. It checks that replay and fill take the slot before core traffic: a scheduler with the priority inverted would let a core read overwrite a replay. It drives four requests to one line, mismatched write flags, a tag mismatch on a free port slot, and two IO requests in the same cycle. Wrong merge logic would show up as extra readies, missing stall counts or a lost bypass. It also checks the appended bypass tag and the port-slot folding on ports 2 and 3, which would expose a swapped shift or a modulo error.

// File: rtl/bsched_pkg.sv
package bsched_pkg;
  typedef enum logic [1:0] {
    K_IDLE   = 2'd0,
    K_FILL   = 2'd1,
    K_REPLAY = 2'd2,
    K_CORE   = 2'd3
  } slot_kind_e;
endpackage

// File: rtl/bsched_addr_split.sv
module bsched_addr_split #(
  parameter int ADDR_W = 12,
  parameter int OFF_W  = 2,
  parameter int BANK_W = 1,
  parameter int SET_W  = 2,
  localparam int TAG_W = ADDR_W - OFF_W - BANK_W - SET_W,
  localparam int BW    = (BANK_W > 0) ? BANK_W : 1,
  localparam int SW    = (SET_W > 0) ? SET_W : 1,
  localparam int TW    = (TAG_W > 0) ? TAG_W : 1
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [BW-1:0]     bank,
  output logic [SW-1:0]     set,
  output logic [TW-1:0]     tag
);
  if (BANK_W > 0) begin : g_bank
    assign bank = addr[OFF_W +: BANK_W];
  end else begin : g_nobank
    assign bank = '0;
  end
  if (SET_W > 0) begin : g_set
    assign set = addr[OFF_W+BANK_W +: SET_W];
  end else begin : g_noset
    assign set = '0;
  end
  if (TAG_W > 0) begin : g_tag
    assign tag = addr[OFF_W+BANK_W+SET_W +: TAG_W];
  end else begin : g_notag
    assign tag = '0;
  end
endmodule

// File: rtl/bsched_init_gate.sv
module bsched_init_gate #(
  parameter int CYCLES = 8,
  localparam int CW = $clog2(CYCLES + 1)
) (
  input  logic clk,
  input  logic rst,
  output logic busy
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)           cnt <= CW'(CYCLES);
    else if (cnt != 0) cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != 0);

  // R1
  busy_drain_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (cnt <= $past(cnt)));
endmodule

// File: rtl/bsched_stall_ctr.sv
module bsched_stall_ctr #(
  parameter int CNT_W = 16,
  parameter int INC_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [INC_W-1:0] inc,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst)                          cnt <= '0;
    else if (cnt > MAXV - CNT_W'(inc)) cnt <= MAXV;
    else                              cnt <= cnt + CNT_W'(inc);
  end

  // R7
  ctr_monotone_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (cnt >= $past(cnt)));
endmodule

// File: rtl/bank_req_sched.sv
module bank_req_sched
  import bsched_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int OFF_W      = 2,
  parameter int BANK_W     = 1,
  parameter int SET_W      = 2,
  parameter int WAYS       = 2,
  parameter int NUM_PORTS  = 4,
  parameter int PPB        = 2,
  parameter int CTAG_W     = 4,
  parameter int CNT_W      = 16,
  parameter bit WRITE_BACK = 1'b1,
  localparam int NB    = 1 << BANK_W,
  localparam int TAG_W = ADDR_W - OFF_W - BANK_W - SET_W,
  localparam int BW    = (BANK_W > 0) ? BANK_W : 1,
  localparam int SW    = (SET_W > 0) ? SET_W : 1,
  localparam int TW    = (TAG_W > 0) ? TAG_W : 1,
  localparam int PW    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
  localparam int IW    = $clog2(NUM_PORTS + 1)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NB-1:0]               replay_rdy,
  input  logic [NB-1:0]               fill_rdy,
  input  logic [NB-1:0]               mshr_full,
  input  logic [NUM_PORTS-1:0]        core_valid,
  input  logic [NUM_PORTS-1:0]        core_io,
  input  logic [NUM_PORTS-1:0]        core_write,
  input  logic [NUM_PORTS*ADDR_W-1:0] core_addr,
  input  logic [NUM_PORTS*CTAG_W-1:0] core_tag,
  output logic [NUM_PORTS-1:0]        core_ready,
  output logic [NB-1:0]               replay_pop,
  output logic [NB-1:0]               fill_pop,
  output logic [NB*2-1:0]             slot_kind,
  output logic [NB-1:0]               slot_write,
  output logic [NB*SW-1:0]            slot_set,
  output logic [NB*TW-1:0]            slot_tag,
  output logic [NB*PPB-1:0]           slot_pmask,
  output logic [NB*PPB*PW-1:0]        slot_psrc,
  output logic                        byp_valid,
  output logic                        byp_write,
  output logic [ADDR_W-1:0]           byp_addr,
  output logic [CTAG_W+PW-1:0]        byp_tag,
  output logic [CNT_W-1:0]            mshr_stalls,
  output logic [CNT_W-1:0]            bank_stalls
);
  localparam int INIT_CYCLES = (1 << SET_W) * WAYS;

  logic          busy;
  logic [BW-1:0] p_bank [NUM_PORTS];
  logic [SW-1:0] p_set  [NUM_PORTS];
  logic [TW-1:0] p_tag  [NUM_PORTS];

  bsched_init_gate #(.CYCLES(INIT_CYCLES)) u_init (
    .clk(clk), .rst(rst), .busy(busy)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_split
    bsched_addr_split #(
      .ADDR_W(ADDR_W), .OFF_W(OFF_W), .BANK_W(BANK_W), .SET_W(SET_W)
    ) u_split (
      .addr(core_addr[p*ADDR_W +: ADDR_W]),
      .bank(p_bank[p]), .set(p_set[p]), .tag(p_tag[p])
    );
  end

  // next-slot state built by the scan
  slot_kind_e      nk    [NB];
  logic            nwr   [NB];
  logic [SW-1:0]   nset  [NB];
  logic [TW-1:0]   ntag  [NB];
  logic [PPB-1:0]  nmask [NB];
  logic [PW-1:0]   nsrc  [NB][PPB];
  logic            byp_take;
  logic [PW-1:0]   byp_sel;
  logic [IW-1:0]   ms_inc, bs_inc;

  always_comb begin
    int b;
    int s;
    core_ready = '0;
    replay_pop = '0;
    fill_pop   = '0;
    byp_take   = 1'b0;
    byp_sel    = '0;
    ms_inc     = '0;
    bs_inc     = '0;
    for (int i = 0; i < NB; i++) begin
      nk[i]    = K_IDLE;
      nwr[i]   = 1'b0;
      nset[i]  = '0;
      ntag[i]  = '0;
      nmask[i] = '0;
      for (int j = 0; j < PPB; j++) nsrc[i][j] = '0;
      if (!busy && replay_rdy[i]) begin
        nk[i] = K_REPLAY;
        replay_pop[i] = 1'b1;
      end else if (!busy && fill_rdy[i]) begin
        nk[i] = K_FILL;
        fill_pop[i] = 1'b1;
      end
    end
    for (int p = 0; p < NUM_PORTS; p++) begin
      b = int'(p_bank[p]);
      s = p % PPB;
      if (!busy && core_valid[p]) begin
        if (core_io[p]) begin
          if (!byp_take) begin
            byp_take      = 1'b1;
            byp_sel       = PW'(p);
            core_ready[p] = 1'b1;
          end
        end else if (nk[b] == K_REPLAY || nk[b] == K_FILL) begin
          // slot taken by a higher-priority source: silent skip
        end else if (mshr_full[b] && (!core_write[p] || WRITE_BACK)) begin
          ms_inc = ms_inc + IW'(1);
        end else if (nk[b] == K_CORE) begin
          if (nwr[b] == core_write[p] && nset[b] == p_set[p] &&
              ntag[b] == p_tag[p] && !nmask[b][s]) begin
            nmask[b][s]   = 1'b1;
            nsrc[b][s]    = PW'(p);
            core_ready[p] = 1'b1;
          end else begin
            bs_inc = bs_inc + IW'(1);
          end
        end else begin
          nk[b]         = K_CORE;
          nwr[b]        = core_write[p];
          nset[b]       = p_set[p];
          ntag[b]       = p_tag[p];
          nmask[b][s]   = 1'b1;
          nsrc[b][s]    = PW'(p);
          core_ready[p] = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_kind  <= '0;
      slot_pmask <= '0;
      byp_valid  <= 1'b0;
    end else begin
      for (int i = 0; i < NB; i++) begin
        slot_kind[i*2 +: 2]      <= nk[i];
        slot_pmask[i*PPB +: PPB] <= nmask[i];
      end
      byp_valid <= byp_take;
    end
    for (int i = 0; i < NB; i++) begin
      slot_write[i]        <= nwr[i];
      slot_set[i*SW +: SW] <= nset[i];
      slot_tag[i*TW +: TW] <= ntag[i];
      for (int j = 0; j < PPB; j++)
        slot_psrc[(i*PPB+j)*PW +: PW] <= nsrc[i][j];
    end
    if (byp_take) begin
      byp_write <= core_write[byp_sel];
      byp_addr  <= core_addr[int'(byp_sel)*ADDR_W +: ADDR_W];
      byp_tag   <= {core_tag[int'(byp_sel)*CTAG_W +: CTAG_W], byp_sel};
    end
  end

  bsched_stall_ctr #(.CNT_W(CNT_W), .INC_W(IW)) u_ms_ctr (
    .clk(clk), .rst(rst), .inc(ms_inc), .cnt(mshr_stalls)
  );
  bsched_stall_ctr #(.CNT_W(CNT_W), .INC_W(IW)) u_bs_ctr (
    .clk(clk), .rst(rst), .inc(bs_inc), .cnt(bank_stalls)
  );

  // R1
  init_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> (core_ready == '0 && replay_pop == '0 && fill_pop == '0));

  // R10
  ready_has_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (core_ready & ~core_valid) == '0);

  // R4
  one_bypass_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(core_ready & core_io & core_valid) <= 1);

  for (genvar i = 0; i < NB; i++) begin : g_chk
    // R2
    single_source_chk: assert property (@(posedge clk) disable iff (rst)
      $onehot0({replay_pop[i], fill_pop[i]}));
    // R6
    core_slot_mask_chk: assert property (@(posedge clk) disable iff (rst)
      (slot_kind[i*2 +: 2] == 2'd3) |-> (slot_pmask[i*PPB +: PPB] != '0));
    // R2
    replay_to_slot_chk: assert property (@(posedge clk) disable iff (rst)
      replay_pop[i] |=> (slot_kind[i*2 +: 2] == 2'd2));
  end
endmodule

// File: tb/bank_req_sched_tb.sv
module bank_req_sched_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 4;

  typedef struct packed {
    logic [1:0]      rep;
    logic [1:0]      fil;
    logic [1:0]      mf;
    logic [3:0]      cv;
    logic [3:0]      cio;
    logic [3:0]      cw;
    logic [3:0][11:0] a;
    logic [3:0]      rdy;
    logic [1:0]      k1;
    logic [1:0]      k0;
    logic [2:0]      dms;
    logic [2:0]      dbs;
  } vec_t;

  function automatic logic [11:0] mk(input int b, input int s, input int t);
    return {7'(t), 2'(s), 1'(b), 2'b00};
  endfunction

  localparam vec_t VT [6] = '{
    // V0: four reads to one line in bank0; ports 2,3 find their slot taken (R6, R8)
    '{2'b00, 2'b00, 2'b00, 4'b1111, 4'b0000, 4'b0000,
      {mk(0,1,5), mk(0,1,5), mk(0,1,5), mk(0,1,5)},
      4'b0011, 2'd0, 2'd3, 3'd0, 3'd2},
    // V1: replay on bank0, fill on bank1, core skipped silently (R2, R3)
    '{2'b01, 2'b10, 2'b00, 4'b0011, 4'b0000, 4'b0000,
      {12'h0, 12'h0, mk(1,1,5), mk(0,1,5)},
      4'b0000, 2'd1, 2'd2, 3'd0, 3'd0},
    // V2: bank1 MSHR full stalls read and write; port3 IO (R7, R4)
    '{2'b00, 2'b00, 2'b10, 4'b1111, 4'b1000, 4'b0010,
      {mk(0,0,0), mk(0,3,9), mk(1,0,2), mk(1,0,1)},
      4'b1100, 2'd0, 2'd3, 3'd2, 3'd0},
    // V3: write/read mismatch and tag mismatch (R8)
    '{2'b00, 2'b00, 2'b00, 4'b1111, 4'b0000, 4'b0001,
      {mk(1,1,6), mk(1,1,4), mk(0,2,3), mk(0,2,3)},
      4'b0101, 2'd3, 2'd3, 3'd0, 3'd2},
    // V4: fills only (R2)
    '{2'b00, 2'b11, 2'b00, 4'b0000, 4'b0000, 4'b0000,
      {12'h0, 12'h0, 12'h0, 12'h0},
      4'b0000, 2'd1, 2'd1, 3'd0, 3'd0},
    // V5: two IO requests, lowest index wins (R4)
    '{2'b00, 2'b00, 2'b00, 4'b1010, 4'b1010, 4'b0000,
      {12'h0, 12'h0, 12'h0, 12'h0},
      4'b0010, 2'd0, 2'd0, 3'd0, 3'd0}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0]  replay_rdy = '0, fill_rdy = '0, mshr_full = '0;
  logic [3:0]  core_valid = '0, core_io = '0, core_write = '0;
  logic [47:0] core_addr = '0;
  logic [15:0] core_tag = '0;
  logic [3:0]  core_ready;
  logic [1:0]  replay_pop, fill_pop, slot_write;
  logic [3:0]  slot_kind, slot_set, slot_pmask;
  logic [13:0] slot_tag;
  logic [7:0]  slot_psrc;
  logic        byp_valid, byp_write;
  logic [11:0] byp_addr;
  logic [5:0]  byp_tag;
  logic [15:0] mshr_stalls, bank_stalls;

  int n_chk = 0;
  int n_fail = 0;
  int exp_ms = 0;
  int exp_bs = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bank_req_sched dut_i (
    .clk(clk), .rst(rst), .replay_rdy(replay_rdy), .fill_rdy(fill_rdy),
    .mshr_full(mshr_full), .core_valid(core_valid), .core_io(core_io),
    .core_write(core_write), .core_addr(core_addr), .core_tag(core_tag),
    .core_ready(core_ready), .replay_pop(replay_pop), .fill_pop(fill_pop),
    .slot_kind(slot_kind), .slot_write(slot_write), .slot_set(slot_set),
    .slot_tag(slot_tag), .slot_pmask(slot_pmask), .slot_psrc(slot_psrc),
    .byp_valid(byp_valid), .byp_write(byp_write), .byp_addr(byp_addr),
    .byp_tag(byp_tag), .mshr_stalls(mshr_stalls), .bank_stalls(bank_stalls)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    replay_rdy = '0; fill_rdy = '0; mshr_full = '0;
    core_valid = '0; core_io = '0; core_write = '0;
    core_addr = '0; core_tag = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    // R11 reset state
    repeat (3) @(posedge clk);
    #1;
    chk("R11 slot_kind", 64'(slot_kind), 64'h0);
    chk("R11 byp_valid", 64'(byp_valid), 64'h0);
    chk("R11 counters", 64'({mshr_stalls, bank_stalls}), 64'h0);

    // R1 clearing window: 8 edges
    @(negedge clk);
    core_valid = 4'b0001;
    core_addr[11:0] = mk(0, 0, 1);
    replay_rdy = 2'b01;
    rst = 1'b0;
    repeat (7) @(posedge clk);
    #1;
    chk("R1 ready after 7 edges", 64'(core_ready), 64'h0);
    chk("R1 no pop after 7 edges", 64'(replay_pop), 64'h0);
    @(posedge clk);
    #1;
    chk("R1 replay pops after 8 edges", 64'(replay_pop), 64'h1);
    replay_rdy = '0;
    #1;
    chk("R1 ready after 8 edges", 64'(core_ready), 64'h1);
    @(negedge clk);
    idle_inputs();
    @(posedge clk);

    // table walk
    for (int v = 0; v < 6; v++) begin
      @(negedge clk);
      replay_rdy = VT[v].rep; fill_rdy = VT[v].fil; mshr_full = VT[v].mf;
      core_valid = VT[v].cv; core_io = VT[v].cio; core_write = VT[v].cw;
      core_addr = VT[v].a; core_tag = 16'h3579;
      #1;
      chk($sformatf("R10 ready vec%0d", v), 64'(core_ready), 64'(VT[v].rdy));
      @(posedge clk);
      #1;
      exp_ms += int'(VT[v].dms);
      exp_bs += int'(VT[v].dbs);
      chk($sformatf("R2 kind bank0 vec%0d", v), 64'(slot_kind[1:0]), 64'(VT[v].k0));
      chk($sformatf("R2 kind bank1 vec%0d", v), 64'(slot_kind[3:2]), 64'(VT[v].k1));
      chk($sformatf("R7 mshr_stalls vec%0d", v), 64'(mshr_stalls), 64'(exp_ms));
      chk($sformatf("R8 bank_stalls vec%0d", v), 64'(bank_stalls), 64'(exp_bs));
    end

    // R5, R6: fields of a merged slot in bank1
    @(negedge clk);
    idle_inputs();
    core_valid = 4'b0011;
    core_addr[11:0]  = mk(1, 3, 8'h55);
    core_addr[23:12] = mk(1, 3, 8'h55);
    @(posedge clk);
    #1;
    chk("R5 set bank1", 64'(slot_set[3:2]), 64'h3);
    chk("R5 tag bank1", 64'(slot_tag[13:7]), 64'h55);
    chk("R6 pmask bank1", 64'(slot_pmask[3:2]), 64'h3);
    chk("R6 psrc bank1", 64'(slot_psrc[7:4]), 64'h4);

    // R6: ports 2 and 3 fold onto slots 0 and 1
    @(negedge clk);
    idle_inputs();
    core_valid = 4'b1100;
    core_addr[35:24] = mk(0, 1, 2);
    core_addr[47:36] = mk(0, 1, 2);
    #1;
    chk("R6 ready ports 2,3", 64'(core_ready), 64'hC);
    @(posedge clk);
    #1;
    chk("R6 pmask bank0", 64'(slot_pmask[1:0]), 64'h3);
    chk("R6 psrc bank0", 64'(slot_psrc[3:0]), 64'hE);

    // R9 bypass tag and fields
    @(negedge clk);
    idle_inputs();
    core_valid = 4'b0100; core_io = 4'b0100; core_write = 4'b0100;
    core_addr[35:24] = 12'h123;
    core_tag[11:8] = 4'hB;
    @(posedge clk);
    #1;
    chk("R9 byp_valid", 64'(byp_valid), 64'h1);
    chk("R9 byp_tag", 64'(byp_tag), 64'd46);
    chk("R9 byp_addr", 64'(byp_addr), 64'h123);
    chk("R9 byp_write", 64'(byp_write), 64'h1);
    @(negedge clk);
    idle_inputs();
    @(posedge clk);
    #1;
    chk("R9 byp_valid drops", 64'(byp_valid), 64'h0);

    // R2 pops: replay beats fill
    @(negedge clk);
    replay_rdy = 2'b11; fill_rdy = 2'b11;
    #1;
    chk("R2 replay_pop", 64'(replay_pop), 64'h3);
    chk("R2 fill_pop blocked", 64'(fill_pop), 64'h0);
    @(negedge clk);
    replay_rdy = 2'b00; fill_rdy = 2'b01;
    #1;
    chk("R2 fill_pop alone", 64'(fill_pop), 64'h1);
    @(negedge clk);
    idle_inputs();
    @(posedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule